// File: doc/BRIEF.md
# Serial-to-Byte Deserializer with Bit Slip

This block gathers a continuous one-bit serial stream, taken on every rising edge of the serial clock, into 8-bit parallel words. A modulo-8 frame counter decides where each word ends. When it wraps, the word just completed is copied into an output holding register. The same counter provides a divide-by-eight parallel clock, and the output word changes exactly where that clock falls. A one-cycle word-valid pulse comes with each load, so a consumer in the serial clock domain can take the data without watching the derived clock.

Word framing is corrected with an asynchronous realignment request. The request passes through a two-flop synchronizer. It counts only after it has been seen high on two consecutive synchronized samples. An accepted request holds the frame counter for one serial cycle. The word in progress then spans nine serial bits, its first bit is thrown away, and every later word boundary moves by one bit. Each request pulse gives one slip, however long it stays high. An upstream framing detector can therefore pulse the request once for each bit of misalignment it sees.

Top module: `deser_bitslip`

## Requirements
- R1: A synchronous active-high reset clears the frame counter, shift register, output register and slip logic: `par_out` = 0, `word_vld` = 0, `par_clk` = 0. After reset is released, the first word is loaded on the 8th rising edge.
- R2: Within a word, the first serial bit received appears on `par_out[7]` and the last on `par_out[0]`.
- R3: Without slips, `word_vld` is high for exactly one serial cycle in every eight, on the same edge at which `par_out` takes the new word. `par_out` holds its value at all other times.
- R4: `par_clk` is low while the frame count is 0 to 3 and high while it is 4 to 7. In an aligned word it is therefore high after the 4th through 7th bit edges, and `par_out` and `word_vld` change only on an edge where `par_clk` falls.
- R5: `sync_req` is resynchronized through two flops. A request seen high on only one serial edge causes no slip.
- R6: An accepted request holds the frame counter for one edge: the 4th edge after `sync_req` is first sampled high. The word in progress then takes nine bits, drops its first bit, and is loaded on the 9th edge. `par_clk` stays low for four edges in that word.
- R7: Each request pulse causes exactly one slip, however long it stays high. A further slip needs `sync_req` to go low and then high again.
- R8: Reset asserted mid-stream discards the partial word and any pending request, and word framing restarts from the first bit after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| sync_req | input | 1 | Asynchronous realignment request, active high |
| par_out | output | 8 | Parallel word, first received bit in the MSB |
| par_clk | output | 1 | Divide-by-eight parallel clock |
| word_vld | output | 1 | One-cycle pulse marking each new parallel word |

## Verification
The hardest case to reach from the ports is a slip whose effect has to be pinned to a single bit. The request is raised at the start of a word and held for three edges, so the counter stall falls in the middle of that word. The bench then feeds one junk bit ahead of a known byte and expects that byte to appear on the ninth edge. A request held high across three words shows that no second bit is dropped. A single-edge request shows that the qualification filter rejects it, and a pulse issued later shows that the slip logic has re-armed.

// File: rtl/deser_pkg.sv
package deser_pkg;
    localparam int DES_W      = 8;
    localparam int SYNC_FLOPS = 2;
    localparam int SYNC_HOLD  = 2;

    typedef logic [DES_W-1:0] des_word_t;

    typedef struct packed {
        des_word_t data;
        logic      vld;
    } des_out_t;

    function automatic des_word_t shift_in(des_word_t cur, logic bit_in);
        return {cur[DES_W-2:0], bit_in};
    endfunction
endpackage

// File: rtl/deser_sync_qual.sv
module deser_sync_qual #(
    parameter int STAGES   = deser_pkg::SYNC_FLOPS,
    parameter int MIN_HIGH = deser_pkg::SYNC_HOLD
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic slip_o
);
    localparam int HW = $clog2(MIN_HIGH + 1);

    logic [STAGES-1:0] sync_sh;
    logic [HW-1:0]     high_cnt;
    logic              req_s;

    always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[STAGES-2:0], req_async};
    end

    assign req_s = sync_sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst)                         high_cnt <= '0;
        else if (!req_s)                 high_cnt <= '0;
        else if (high_cnt != HW'(MIN_HIGH)) high_cnt <= high_cnt + 1'b1;
    end

    assign slip_o = req_s && (high_cnt == HW'(MIN_HIGH - 1));

    // R7
    slip_single_chk: assert property (@(posedge clk) disable iff (rst)
        slip_o |=> !slip_o);

    // R5
    slip_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        slip_o |-> $past(req_s));
endmodule

// File: rtl/deser_frame_ctr.sv
module deser_frame_ctr #(
    parameter int W = deser_pkg::DES_W
) (
    input  logic clk,
    input  logic rst,
    input  logic slip_i,
    output logic load_o,
    output logic phase_hi_o
);
    localparam int CNT_W = $clog2(W);
    localparam int HALF  = W / 2;

    logic [CNT_W-1:0] cnt_q;

    assign load_o     = (cnt_q == CNT_W'(W - 1)) && !slip_i;
    assign phase_hi_o = (cnt_q >= CNT_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (slip_i)                  cnt_q <= cnt_q;
        else if (cnt_q == CNT_W'(W - 1))  cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    // R6
    slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        slip_i |=> $stable(phase_hi_o));
endmodule

// File: rtl/deser_shift_out.sv
module deser_shift_out
    import deser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_i,
    input  logic      load_i,
    output des_out_t  word_o
);
    des_word_t sreg_q;
    des_word_t next_w;
    des_out_t  out_q;

    assign next_w = shift_in(sreg_q, ser_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            out_q  <= '0;
        end else begin
            sreg_q    <= next_w;
            out_q.vld <= load_i;
            if (load_i) out_q.data <= next_w;
        end
    end

    assign word_o = out_q;

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_q.vld && !$past(rst)) |-> $stable(out_q.data));
endmodule

// File: rtl/deser_bitslip.sv
module deser_bitslip
    import deser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             sync_req,
    output logic [DES_W-1:0] par_out,
    output logic             par_clk,
    output logic             word_vld
);
    logic     slip;
    logic     load;
    des_out_t word;

    deser_sync_qual #(.STAGES(SYNC_FLOPS), .MIN_HIGH(SYNC_HOLD)) u_sync (
        .clk(clk), .rst(rst), .req_async(sync_req), .slip_o(slip)
    );

    deser_frame_ctr #(.W(DES_W)) u_ctr (
        .clk(clk), .rst(rst), .slip_i(slip), .load_o(load), .phase_hi_o(par_clk)
    );

    deser_shift_out u_sr (
        .clk(clk), .rst(rst), .ser_i(ser_in), .load_i(load), .word_o(word)
    );

    assign par_out  = word.data;
    assign word_vld = word.vld;

    // R4
    load_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> ($past(par_clk) && !par_clk));

    // R6
    slip_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        slip |=> !word_vld);
endmodule

// File: tb/sim_deser_bitslip.sv
module sim_deser_bitslip;
    logic       clk = 1'b0;
    logic       rst, ser_in, sync_req;
    logic [7:0] par_out;
    logic       par_clk, word_vld;
    int         checks = 0;
    int         fails  = 0;

    always #10 clk = ~clk;

    deser_bitslip u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .sync_req(sync_req),
        .par_out(par_out), .par_clk(par_clk), .word_vld(word_vld)
    );

    localparam logic [7:0] VEC [8] = '{8'hA5, 8'h3C, 8'h81, 8'h7E,
                                        8'h00, 8'hFF, 8'h96, 8'h12};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        ser_in = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    // junk=1 : one extra leading bit expected to be dropped by a slip
    // sync_ticks>0 : sync_req high for that many leading ticks, then low
    task automatic send_word(input logic [7:0] b, input logic [7:0] prev,
                             input bit junk, input int sync_ticks, input string req);
        int n = junk ? 9 : 8;
        int vld_bad = 0, hold_bad = 0, pc_bad = 0;
        for (int t = 0; t < n; t++) begin
            logic bv;
            bit   pc_exp;
            if (sync_ticks > 0) sync_req = (t < sync_ticks);
            bv = junk ? ((t == 0) ? ~b[7] : b[8 - t]) : b[7 - t];
            tick(bv);
            pc_exp = junk ? (t >= 4 && t <= 7) : (t >= 3 && t <= 6);
            if (par_clk !== pc_exp) pc_bad++;
            if (t != n - 1) begin
                if (word_vld !== 1'b0) vld_bad++;
                if (par_out !== prev) hold_bad++;
            end
        end
        chk(word_vld === 1'b1 && par_out === b, {req, " word"}, {word_vld, par_out}, {1'b1, b});
        chk(vld_bad == 0, {req, " R3 vld pulse spacing"}, vld_bad, 0);
        chk(hold_bad == 0, {req, " R3 output hold"}, hold_bad, 0);
        chk(pc_bad == 0, {req, " R4 par_clk phase"}, pc_bad, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        rst = 1'b1; ser_in = 1'b0; sync_req = 1'b0;
        @(negedge clk);
        tick(1'b1); tick(1'b1); tick(1'b0);
        // R1 reset state
        chk(par_out === 8'h00 && word_vld === 1'b0 && par_clk === 1'b0, "R1 reset",
            {par_out, word_vld, par_clk}, 0);
        rst = 1'b0;
        prev = 8'h00;
        // R1 first load after 8 edges; R2 bit order over the table
        foreach (VEC[i]) begin
            send_word(VEC[i], prev, 1'b0, 0, (i == 0) ? "R1" : "R2");
            prev = VEC[i];
        end
        // R5 single-edge request is filtered out
        send_word(8'hC3, prev, 1'b0, 1, "R5"); prev = 8'hC3;
        send_word(8'h5A, prev, 1'b0, 0, "R5"); prev = 8'h5A;
        // R6 accepted request drops one bit
        send_word(8'hE7, prev, 1'b1, 3, "R6"); prev = 8'hE7;
        send_word(8'h24, prev, 1'b0, 0, "R6"); prev = 8'h24;
        // R7 long request gives exactly one slip
        sync_req = 1'b1;
        send_word(8'h69, prev, 1'b1, 0, "R7"); prev = 8'h69;
        send_word(8'hB4, prev, 1'b0, 0, "R7"); prev = 8'hB4;
        send_word(8'h0F, prev, 1'b0, 3, "R7"); prev = 8'h0F;
        send_word(8'hD2, prev, 1'b0, 0, "R7"); prev = 8'hD2;
        // R7 re-armed after going low
        send_word(8'h4B, prev, 1'b1, 3, "R7"); prev = 8'h4B;
        // R8 mid-stream reset with a pending request
        tick(1'b1); tick(1'b0); tick(1'b1);
        rst = 1'b1; sync_req = 1'b1;
        tick(1'b1); tick(1'b1);
        chk(par_out === 8'h00 && word_vld === 1'b0 && par_clk === 1'b0, "R8 reset clear",
            {par_out, word_vld, par_clk}, 0);
        rst = 1'b0; sync_req = 1'b0;
        send_word(8'h71, 8'h00, 1'b0, 0, "R8");
        send_word(8'h8E, 8'h71, 1'b0, 0, "R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule